// File: doc/BRIEF.md
# Serial Transmitter with Break Frames

This block serializes bytes onto an asynchronous line in the 8N1 format. It can also emit the long low break frame that a LIN-style bus master uses to open a message header. A single holding register sits in front of the shift register, so software can queue one byte while another is on the wire. Bit timing comes from a one-cycle `baud_tick` strobe produced by an external rate generator, and every bit on the line lasts exactly one tick period.

To send a header, software pulses `brk_set` to arm a break and writes any byte. That byte only serves as a trigger: when it moves into the shifter, a frame with thirteen low bit times and one high stop bit goes out instead of the data. While the break is on the line, software may queue the next byte, typically a 0x55 sync pattern. The armed flag clears itself at the end of the break's stop bit, so the queued byte follows as an ordinary frame with no idle gap. Dropping `tx_en` returns everything to idle at once.

Top module: `brk_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `shifter_idle` is 1 and `brk_pending` is 0.
- R2: A normal frame is one low start bit, then the eight data bits with bit 0 first, then one high stop bit. The line sits high whenever no frame is shifting.
- R3: Each bit lasts one `baud_tick` period. A full holding register is moved into an idle shifter on the next tick. If the shifter is busy, the move happens on the tick that ends the current stop bit, so the next start bit follows with no idle bit time.
- R4: If `brk_pending` is 1 when a byte moves into the shifter, a break frame is sent instead: 13 low bit times (start plus twelve), then one high stop bit. The written data is discarded.
- R5: `brk_pending` is set by a `brk_set` pulse while `tx_en` is 1. It stays 1 for the whole break and falls on the tick that ends the break's stop bit.
- R6: A byte written while a break is shifting is sent as a normal frame directly after the break.
- R7: `shifter_idle` is 0 during every break or normal frame and 1 otherwise.
- R8: `buf_empty` returns to 1 in the cycle after the holding register hands its byte to the shifter. A write is accepted whenever `buf_empty` is 1.
- R9: A write while the holding register is full is dropped. This includes a write in the very cycle the register hands off.
- R10: While `tx_en` is 0, the shifter and holding register are cleared, `txd` is 1, `brk_pending` is 0, and both writes and `brk_set` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| tx_en | input | 1 | transmitter enable; 0 clears all state |
| brk_set | input | 1 | one-cycle pulse that arms a break for the next loaded byte |
| baud_tick | input | 1 | one-cycle bit-rate strobe |
| wr_en | input | 1 | write strobe for the holding register |
| wr_data | input | 8 | byte to send |
| txd | output | 1 | serial line, idle high |
| buf_empty | output | 1 | holding register can take a byte |
| shifter_idle | output | 1 | no frame is on the line |
| brk_pending | output | 1 | break armed or in progress |

## Verification
Two events can land on the same tick. The first is the end of a break's stop bit, which clears `brk_pending` while the queued sync byte is loaded; that byte must come out as plain data and not as a second break. This is provoked by queuing 0x55, and random bytes, behind every armed break, and judged on the captured bit stream. The second collision is a write that arrives in the exact cycle the full holding register hands off on a stop-bit tick. The bench times that write from the captured bit count and expects it to be absent from the line.

// File: rtl/brk_uart_tx.sv
module brk_uart_tx #(
  parameter int DATA_W = 8,
  parameter int BRK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              brk_set,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_empty,
  output logic              shifter_idle,
  output logic              brk_pending
);

  localparam int NRM_BITS = DATA_W + 2;
  localparam int BRK_BITS = BRK_ZEROS + 2;
  localparam int MAX_BITS = (NRM_BITS > BRK_BITS) ? NRM_BITS : BRK_BITS;
  localparam int CNT_W = $clog2(MAX_BITS);

  logic              busy, brk_frm, full, sendb;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shf, hold_q;
  logic              last_bit, fin, load, brk_now;

  assign last_bit = brk_frm ? (cnt == CNT_W'(BRK_BITS - 1)) : (cnt == CNT_W'(NRM_BITS - 1));
  assign fin      = busy & baud_tick & last_bit;
  assign load     = tx_en & baud_tick & full & (~busy | last_bit);
  assign brk_now  = sendb & ~(busy & brk_frm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      brk_frm <= 1'b0;
      cnt     <= '0;
      shf     <= '0;
    end else if (!tx_en) begin
      busy    <= 1'b0;
      brk_frm <= 1'b0;
      cnt     <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      brk_frm <= brk_now;
      cnt     <= '0;
      shf     <= hold_q;
    end else if (fin) begin
      busy    <= 1'b0;
      brk_frm <= 1'b0;
      cnt     <= '0;
    end else if (busy && baud_tick) begin
      cnt <= cnt + 1'b1;
      if (cnt != '0) shf <= shf >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      hold_q <= '0;
    end else if (!tx_en || load) begin
      full <= 1'b0;
    end else if (wr_en && !full) begin
      full   <= 1'b1;
      hold_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sendb <= 1'b0;
    else if (!tx_en)           sendb <= 1'b0;
    else if (brk_set)          sendb <= 1'b1;
    else if (brk_frm && fin)   sendb <= 1'b0;
  end

  always_comb begin
    if (!busy)            txd = 1'b1;
    else if (cnt == '0)   txd = 1'b0;
    else if (brk_frm)     txd = (cnt == CNT_W'(BRK_BITS - 1));
    else if (last_bit)    txd = 1'b1;
    else                  txd = shf[0];
  end

  assign buf_empty    = ~full;
  assign shifter_idle = ~busy;
  assign brk_pending  = sendb;

  // R10
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (txd && shifter_idle && buf_empty && !brk_pending));

  // R9
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && tx_en) |=> (hold_q == $past(hold_q)));

  // R5
  brk_clear_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_pending) |-> (!$past(tx_en) || $past(brk_frm && busy && baud_tick && last_bit)));

  // R8
  handoff_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && baud_tick && full && !busy) |=> (buf_empty && !shifter_idle));

  // R7
  idle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shifter_idle) |-> ($past(baud_tick) || !$past(tx_en)));

endmodule

// File: tb/brk_uart_tx_tb.sv
`timescale 1ns/1ps
module brk_uart_tx_tb;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, brk_set = 1'b0, baud_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, buf_empty, shifter_idle, brk_pending;

  int checks = 0, fails = 0, cyc = 0, tdiv = 0;
  bit cap[$];
  bit expq[$];

  always #2.5 clk = ~clk;

  brk_uart_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_set(brk_set),
    .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .buf_empty(buf_empty), .shifter_idle(shifter_idle),
    .brk_pending(brk_pending)
  );

  always @(posedge clk) begin
    #1;
    tdiv = (tdiv == DIV - 1) ? 0 : tdiv + 1;
    baud_tick = (tdiv == DIV - 1);
  end

  always @(negedge clk)
    if (rst_n && baud_tick && !shifter_idle) cap.push_back(txd);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void exp_frame(logic [7:0] b);
    expq.push_back(1'b0);
    for (int i = 0; i < 8; i++) expq.push_back(b[i]);
    expq.push_back(1'b1);
  endfunction

  function automatic void exp_break();
    for (int i = 0; i < 13; i++) expq.push_back(1'b0);
    expq.push_back(1'b1);
  endfunction

  task automatic cmp_stream(string req);
    int bad;
    bad = -1;
    checks++;
    if (cap.size() != expq.size()) bad = 0;
    else for (int i = 0; i < cap.size(); i++) if (bad < 0 && cap[i] != expq[i]) bad = i;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s: actual=%0d bits (idx %0d) expected=%0d bits", req, cap.size(), bad, expq.size());
    end
    cap.delete();
    expq.delete();
  endtask

  task automatic put(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk); brk_set = 1'b1;
    @(negedge clk); brk_set = 1'b0;
  endtask

  task automatic wait_empty();
    while (!buf_empty) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!(shifter_idle && buf_empty)) @(negedge clk);
    repeat (3 * DIV) @(negedge clk);
  endtask

  task automatic wait_bits(int n);
    while (cap.size() < n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] b;
    bit gap;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 txd", txd, 1); chk("R1 buf_empty", buf_empty, 1);
    chk("R1 shifter_idle", shifter_idle, 1); chk("R1 brk_pending", brk_pending, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd after release", txd, 1);

    // R10 writes and brk_set ignored while disabled
    put(8'h3C); arm();
    chk("R10 write ignored", buf_empty, 1);
    chk("R10 brk_set ignored", brk_pending, 0);
    tx_en = 1'b1;
    repeat (4 * DIV) @(negedge clk);
    chk("R10 nothing sent", cap.size(), 0);

    // R2 single frames
    put(8'hA5); exp_frame(8'hA5); wait_done(); cmp_stream("R2 frame A5");
    put(8'h01); exp_frame(8'h01); wait_done(); cmp_stream("R2 frame 01");
    chk("R2 idle high", txd, 1);

    // R3 back-to-back, no gap; R7 busy throughout
    put(8'h96); exp_frame(8'h96);
    while (shifter_idle) @(negedge clk);
    chk("R7 busy during frame", shifter_idle, 0);
    put(8'h4E); exp_frame(8'h4E);
    gap = 0;
    while (cap.size() < 20) begin
      @(negedge clk);
      if (shifter_idle && cap.size() < 20) gap = 1;
    end
    chk("R3 no idle gap", gap, 0);
    wait_done(); cmp_stream("R3 back-to-back stream");
    chk("R7 idle after", shifter_idle, 1);

    // R9 write while full dropped
    put(8'h11); exp_frame(8'h11);
    while (shifter_idle) @(negedge clk);
    put(8'h22); exp_frame(8'h22);
    chk("R8 accepted write fills", buf_empty, 0);
    put(8'h33);
    wait_done(); cmp_stream("R9 drop when full");

    // R9 write in the handoff cycle
    put(8'h5A); exp_frame(8'h5A);
    while (shifter_idle) @(negedge clk);
    put(8'hC3); exp_frame(8'hC3);
    wait_bits(9);
    while (!baud_tick) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hEE;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 empty after handoff", buf_empty, 1);
    wait_done(); cmp_stream("R9 handoff-cycle write dropped");

    // R4 R5 R6 break then sync
    arm();
    chk("R5 armed", brk_pending, 1);
    put(8'hFF); exp_break();
    wait_empty();
    put(8'h55); exp_frame(8'h55);
    wait_bits(7);
    chk("R5 held during break", brk_pending, 1);
    chk("R7 busy during break", shifter_idle, 0);
    wait_bits(14);
    @(negedge clk);
    chk("R5 cleared after break stop", brk_pending, 0);
    wait_done(); cmp_stream("R4 R6 break then sync");

    // R10 disable mid-break
    arm(); put(8'h00);
    wait_bits(5);
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk);
    chk("R10 txd high", txd, 1); chk("R10 idle", shifter_idle, 1);
    chk("R10 empty", buf_empty, 1); chk("R10 brk cleared", brk_pending, 0);
    cap.delete(); expq.delete();
    tx_en = 1'b1;
    put(8'h81); exp_frame(8'h81); wait_done(); cmp_stream("R10 no break after re-enable");

    // random mix
    for (int i = 0; i < 30; i++) begin
      if ($urandom % 4 == 0) begin
        while (!(buf_empty && !brk_pending)) @(negedge clk);
        arm(); put(8'($urandom)); exp_break();
      end
      wait_empty();
      b = 8'($urandom);
      put(b); exp_frame(b);
      repeat ($urandom % 40) @(negedge clk);
    end
    wait_done(); cmp_stream("R4 R6 random stream");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule